// File: doc/BRIEF.md
# Repeater Port Partition Monitor

This block sits beside one port of a multi-port repeater and decides whether the repeater core may accept that port's receive traffic. It watches the port's collision line and counts the start of each collision. Too many collisions in a row isolate the port. A single collision that stays asserted far too long also isolates it. While the port is isolated, its receive-enable flag is held low, so the port can no longer disturb the rest of the segment. The repeater still transmits to an isolated port.

The port rejoins the segment only when the repeater finishes a sufficiently long transmission to it during which no collision was seen. The same clean transmission also clears the consecutive-collision count of a port that is not isolated.

A configuration input turns the isolation function off. While that input is high the port is never isolated, but the collision count keeps running. Neither setting nor clearing that input releases a port that is already isolated. The thresholds are fixed at build time through parameters.

Top module: `ppm_port_partition`

## Requirements
- R1: After reset, `partitioned_o` is 0 and the consecutive-collision count is zero.
- R2: `rx_en_o` equals `crs_i` while `partitioned_o` is 0, and is 0 while `partitioned_o` is 1.
- R3: A collision onset is a clock edge at which `col_i` is sampled 1 after being sampled 0 at the previous edge. Once `CNT_LIMIT` onsets (default 32) have been counted with no clean transmission between them, `partitioned_o` rises at the following clock edge. `CNT_LIMIT`-1 such onsets leave the port connected.
- R4: If `col_i` is sampled 1 at `LONG_LEN` consecutive edges (default 512), `partitioned_o` rises at the next edge. A run of `LONG_LEN`-1 samples does not isolate the port.
- R5: A clean transmission clears the consecutive-collision count. It is a run of at least `CLEAN_LEN` consecutive edges (default 128) with `tx_act_i` sampled 1 and `col_i` sampled 0, and it ends at the first edge that samples `tx_act_i` at 0.
- R6: An isolated port is released (`partitioned_o` falls) at the edge that ends a clean transmission. A shorter transmission does not release it, and neither does one during which `col_i` was sampled 1.
- R7: While `part_dis_i` is 1, `partitioned_o` never rises, whatever the collision activity.
- R8: `part_dis_i` never releases an isolated port. Collision onsets keep being counted while it is 1. After it returns to 0 with the count already at `CNT_LIMIT`, the port is isolated at the next edge.
- R9: A collision during a transmission counts as an onset, and that transmission does not count as clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| col_i | input | 1 | Collision indication from the port's transceiver |
| crs_i | input | 1 | Carrier / receive activity on the port |
| tx_act_i | input | 1 | Repeater is transmitting to this port |
| part_dis_i | input | 1 | 1 = isolation function disabled |
| rx_en_o | output | 1 | Receive enable toward the repeater core |
| partitioned_o | output | 1 | 1 = port is isolated |

## Verification
A wrong collision count or run length shows up as `partitioned_o` rising one cycle early or late relative to the limit-th onset or the `LONG_LEN`-th collision sample. Such faults are exposed by runs that stop exactly one below each limit. A stuck dirty flag or a transmission timer that is off by one appears at the first release attempt. In that case the port stays isolated after a 128-cycle clean transmission, or is released after a 127-cycle one. Because `rx_en_o` follows the isolation state directly, any state error is visible on both outputs in the cycle it occurs.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    // Isolation state of the port
    typedef enum logic {
        ST_LINKED   = 1'b0,
        ST_ISOLATED = 1'b1
    } ppm_state_e;

    // Reasons that may isolate the port in a given cycle
    typedef struct packed {
        logic by_count;
        logic by_length;
    } ppm_trig_t;

endpackage

// File: rtl/ppm_run_timer.sv
// Counts consecutive cycles with level_i high, saturating at MAX.
module ppm_run_timer #(
    parameter int unsigned MAX = 512,
    localparam int unsigned W  = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         level_i,
    output logic [W-1:0] run_o,
    output logic         full_o
);

    typedef struct packed {
        logic [W-1:0] run;
    } run_regs_t;

    run_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!level_i) begin
            r_d.run = '0;
        end else if (r_q.run != W'(MAX)) begin
            r_d.run = r_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_o  = r_q.run;
    assign full_o = (r_q.run == W'(MAX));

endmodule

// File: rtl/ppm_event_counter.sv
// Saturating event counter with synchronous clear (clear wins).
module ppm_event_counter #(
    parameter int unsigned LIMIT = 32,
    localparam int unsigned W    = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         hit_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.cnt = '0;
        end else if (inc_i && (r_q.cnt != W'(LIMIT))) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_o = r_q.cnt;
    assign hit_o = (r_q.cnt == W'(LIMIT));

endmodule

// File: rtl/ppm_port_partition.sv
module ppm_port_partition
    import ppm_pkg::*;
#(
    parameter int unsigned CNT_LIMIT = 32,
    parameter int unsigned LONG_LEN  = 512,
    parameter int unsigned CLEAN_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_i,
    input  logic crs_i,
    input  logic tx_act_i,
    input  logic part_dis_i,
    output logic rx_en_o,
    output logic partitioned_o
);

    localparam int unsigned CNT_W  = $clog2(CNT_LIMIT + 1);
    localparam int unsigned LONG_W = $clog2(LONG_LEN + 1);
    localparam int unsigned TX_W   = $clog2(CLEAN_LEN + 1);

    typedef struct packed {
        ppm_state_e state;
        logic       col_prev;
        logic       tx_dirty;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic [CNT_W-1:0]  col_cnt;
    logic [LONG_W-1:0] col_run;
    logic [TX_W-1:0]   tx_run;
    logic              cnt_hit;
    logic              col_long;
    logic              tx_long;
    logic              col_onset;
    logic              clean_end;
    ppm_trig_t         trig;

    // Consecutive-collision counter
    ppm_event_counter #(.LIMIT(CNT_LIMIT)) u_col_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (col_onset),
        .clr_i (clean_end),
        .cnt_o (col_cnt),
        .hit_o (cnt_hit)
    );

    // Length of the current collision
    ppm_run_timer #(.MAX(LONG_LEN)) u_col_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (col_i),
        .run_o   (col_run),
        .full_o  (col_long)
    );

    // Length of the current transmission to the port
    ppm_run_timer #(.MAX(CLEAN_LEN)) u_tx_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (tx_act_i),
        .run_o   (tx_run),
        .full_o  (tx_long)
    );

    assign col_onset = col_i && !r_q.col_prev;
    assign clean_end = !tx_act_i && tx_long && !r_q.tx_dirty;

    always_comb begin
        r_d            = r_q;
        r_d.col_prev   = col_i;
        r_d.tx_dirty   = tx_act_i ? (r_q.tx_dirty | col_i) : 1'b0;
        trig.by_count  = cnt_hit;
        trig.by_length = col_long;

        case (r_q.state)
            ST_LINKED: begin
                if (!clean_end && (|trig) && !part_dis_i) begin
                    r_d.state = ST_ISOLATED;
                end
            end
            ST_ISOLATED: begin
                if (clean_end) begin
                    r_d.state = ST_LINKED;
                end
            end
            default: r_d.state = ST_LINKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_LINKED, col_prev: 1'b0, tx_dirty: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign partitioned_o = (r_q.state == ST_ISOLATED);
    assign rx_en_o       = crs_i && (r_q.state == ST_LINKED);

    // Counter values are observed only through their limit flags here
    logic unused_vals;
    assign unused_vals = ^{col_cnt, col_run, tx_run};

endmodule

// File: rtl/ppm_port_partition_chk.sv
module ppm_port_partition_chk #(
    parameter int unsigned LONG_LEN = 512
) (
    input logic clk,
    input logic rst_n,
    input logic col_i,
    input logic crs_i,
    input logic tx_act_i,
    input logic part_dis_i,
    input logic rx_en_o,
    input logic partitioned_o
);

    localparam int unsigned RW = $clog2(LONG_LEN + 1);

    // Independent window counter for long collisions
    logic [RW-1:0] chk_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_run <= '0;
        end else if (!col_i) begin
            chk_run <= '0;
        end else if (chk_run != RW'(LONG_LEN)) begin
            chk_run <= chk_run + 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !partitioned_o); // R1
    AST_RXEN_NEEDS_CRS: assert property (@(posedge clk) disable iff (!rst_n) rx_en_o |-> crs_i); // R2
    AST_RXEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) partitioned_o |-> !rx_en_o); // R2
    AST_LONG_ISOLATES: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_run == RW'(LONG_LEN) && !part_dis_i) |=> partitioned_o); // R4
    AST_HOLD_DURING_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (partitioned_o && tx_act_i) |=> partitioned_o); // R6
    AST_RELEASE_AT_TX_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(partitioned_o) |-> (!$past(tx_act_i) && $past(tx_act_i, 2))); // R6
    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (part_dis_i && !partitioned_o) |=> !partitioned_o); // R7

endmodule

bind ppm_port_partition ppm_port_partition_chk #(.LONG_LEN(LONG_LEN)) u_chk (.*);

// File: tb/ppm_port_partition_test.sv
module ppm_port_partition_test;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 32;
    localparam int LONG       = 512;
    localparam int CLEAN      = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic col = 1'b0, crs = 1'b0, tx = 1'b0, dis = 1'b0;
    logic rx_en, part;

    int total = 0;
    int bad   = 0;
    string cur_req = "R1";

    // reference model state
    int m_cnt = 0, m_colrun = 0, m_txrun = 0;
    bit m_part = 0, m_dirty = 0, m_colprev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppm_port_partition #(.CNT_LIMIT(LIMIT), .LONG_LEN(LONG), .CLEAN_LEN(CLEAN)) uut (
        .clk(clk), .rst_n(rst_n), .col_i(col), .crs_i(crs), .tx_act_i(tx),
        .part_dis_i(dis), .rx_en_o(rx_en), .partitioned_o(part)
    );

    function automatic int sat(input int v, input int m);
        return (v > m) ? m : v;
    endfunction

    function automatic bit exp_rxen(input bit c, input bit p);
        return c && !p;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    task automatic model_step();
        bit clean, trig;
        clean = !tx && (m_txrun >= CLEAN) && !m_dirty;
        trig  = (m_cnt >= LIMIT) || (m_colrun >= LONG);
        if (clean) m_part = 0;
        else if (trig && !dis) m_part = 1;
        if (clean) m_cnt = 0;
        else if (col && !m_colprev) m_cnt = sat(m_cnt + 1, LIMIT);
        m_colrun  = col ? sat(m_colrun + 1, LONG) : 0;
        m_txrun   = tx ? sat(m_txrun + 1, CLEAN) : 0;
        m_dirty   = tx ? (m_dirty | col) : 1'b0;
        m_colprev = col;
    endtask

    // inputs are set at a falling edge; outputs checked at the next falling edge
    task automatic cyc(input bit c, input bit t);
        col = c;
        tx  = t;
        crs = $urandom_range(0, 1);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(part == m_part, cur_req, part, m_part);
        chk(rx_en == exp_rxen(crs, m_part), "R2", rx_en, exp_rxen(crs, m_part));
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0);
            cyc(0, 0);
        end
    endtask

    task automatic hold_col(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0);
        cyc(0, 0);
    endtask

    // transmission of n cycles, collision at cycle col_at (-1 = none), then end
    task automatic tx_run(input int n, input int col_at);
        for (int i = 0; i < n; i++) cyc(i == col_at, 1);
        cyc(0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(part == 1'b0, "R1", part, 0);
        chk(rx_en == 1'b0, "R1", rx_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        crs = 1'b1;
        #1 chk(rx_en == 1'b1, "R2", rx_en, 1);

        // R3: count threshold boundary
        cur_req = "R3";
        pulses(LIMIT - 1);
        chk(part == 1'b0, "R3", part, 0);
        pulses(1);
        chk(part == 1'b1, "R3", part, 1);

        // R6: release only after a long enough clean transmission
        cur_req = "R6";
        tx_run(CLEAN - 1, -1);
        chk(part == 1'b1, "R6", part, 1);
        tx_run(CLEAN + 20, 60);
        chk(part == 1'b1, "R6", part, 1);
        tx_run(CLEAN, -1);
        chk(part == 1'b0, "R6", part, 0);

        // R5: clean transmission clears the count
        cur_req = "R5";
        pulses(LIMIT - 1);
        tx_run(CLEAN, -1);
        pulses(LIMIT - 1);
        chk(part == 1'b0, "R5", part, 0);
        tx_run(CLEAN, -1);

        // R4: long collision boundary
        cur_req = "R4";
        hold_col(LONG - 1);
        chk(part == 1'b0, "R4", part, 0);
        hold_col(LONG);
        chk(part == 1'b1, "R4", part, 1);
        tx_run(CLEAN, -1);
        chk(part == 1'b0, "R6", part, 0);

        // R7: disabled isolation
        cur_req = "R7";
        dis = 1'b1;
        pulses(LIMIT + 5);
        hold_col(LONG + 10);
        chk(part == 1'b0, "R7", part, 0);

        // R8: count kept while disabled; disable bit never releases
        cur_req = "R8";
        dis = 1'b0;
        cyc(0, 0);
        chk(part == 1'b1, "R8", part, 1);
        dis = 1'b1;
        for (int i = 0; i < 20; i++) cyc(0, 0);
        dis = 1'b0;
        for (int i = 0; i < 5; i++) cyc(0, 0);
        chk(part == 1'b1, "R8", part, 1);
        tx_run(CLEAN, -1);
        chk(part == 1'b0, "R8", part, 0);

        // R9: collision inside a transmission counts and spoils it
        cur_req = "R9";
        tx_run(200, 100);
        pulses(LIMIT - 1);
        chk(part == 1'b1, "R9", part, 1);
        tx_run(CLEAN, -1);
        chk(part == 1'b0, "R9", part, 0);

        // constrained random bursts
        cur_req = "R2";
        for (int b = 0; b < 60; b++) begin
            int kind;
            kind = $urandom_range(0, 3);
            dis  = ($urandom_range(0, 4) == 0);
            case (kind)
                0: for (int i = 0; i < $urandom_range(1, 20); i++) cyc(0, 0);
                1: pulses($urandom_range(1, 12));
                2: tx_run($urandom_range(CLEAN - 10, CLEAN + 40),
                          ($urandom_range(0, 2) == 0) ? $urandom_range(0, 60) : -1);
                default: hold_col($urandom_range(LONG - 40, LONG + 20));
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule